// File: doc/BRIEF.md
# Coprocessor Register Access Checker

This block decides whether a processor may move data to or from a register of one of three system coprocessors: the system-control unit (number 15), the debug and power unit (number 14) and the interrupt and bus-control unit (number 13). The instruction decoder presents the following fields together with a one-cycle request strobe:

- the coprocessor number;
- the primary register number;
- the secondary register field CRm;
- the two opcode fields (first opcode and second opcode);
- a flag saying that the processor runs unprivileged;
- a 16-bit word of per-coprocessor access enables.

One cycle later the checker gives a single permit bit. A permit of 1 means accept and a permit of 0 means refuse.

Each coprocessor has its own legality table. The tables are irregular. Some registers accept any second opcode, some are always refused, and some accept only a sparse set of (second opcode, CRm) pairs. The decision is made combinationally by three rule units. The result is captured in a register, which holds its value until the next strobe. This lets the surrounding pipeline sample it at any later time.

Top module: `cp_access_gate`

## Requirements
- R1: Synchronous reset sets permit to 0 (refuse). Permit takes the decision for a request in the cycle after the clock edge that samples `req_valid`=1. Permit keeps that value while `req_valid` is 0, whatever the other inputs do.
- R2: A request with `user_mode`=1 is refused on every coprocessor.
- R3: A request whose coprocessor number is not 13, 14 or 15 is refused.
- R4: On coprocessor 15, a non-zero first opcode is refused. Registers 0 and 1 are accepted when CRm=0, with any second opcode.
- R5: On coprocessor 15, registers 2, 3, 5, 6 and 13 are accepted only when CRm=0 and second opcode=0. Registers 4, 11 and 12 are always refused.
- R6: On coprocessor 15, register 7 is accepted only for these (second opcode, CRm) pairs: (5,2), (0,7), (1,10), (6,5), (0,5), (4,10), (1,6), (0,6) and (1,5).
- R7: On coprocessor 15, register 8 is accepted for second opcode 0 with CRm 5, 6 or 7, and for second opcode 1 with CRm 5 or 6.
- R8: On coprocessor 15, register 9 needs CRm of 0 or 1 and second opcode of 1 or 2. Register 10 needs CRm of 0 or 1 and second opcode of 4 or 8. With the 3-bit second opcode field, 8 cannot occur.
- R9: On coprocessor 15, register 14 needs second opcode 0 and CRm in {9, 0, 8, 3, 4}. Register 15 needs second opcode 0 and CRm 1.
- R10: On coprocessor 13, a request is refused unless both opcodes are 0 and bit 13 of `cp_enable` is 1.
- R11: On coprocessor 13, when the R10 conditions are met, the following are accepted: with CRm=0, registers 0, 4 and 8; with CRm=1, registers 0, 1, 4, 5, 6, 7 and 8. Every other CRm is refused.
- R12: On coprocessor 14, a request is accepted only when CRm and both opcodes are 0 and the register is neither 4 nor 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; fields are sampled when this is 1 |
| cp_num | input | 4 | Coprocessor number |
| reg_num | input | 4 | Primary register number |
| crm | input | 4 | Secondary register field CRm |
| opc1 | input | 3 | First opcode field |
| opc2 | input | 3 | Second opcode field |
| user_mode | input | 1 | 1 when the processor runs unprivileged |
| cp_enable | input | 16 | Per-coprocessor access enable bits |
| permit | output | 1 | Registered decision: 1 accept, 0 refuse |

## Verification
In privileged mode with all enables set, the bench sweeps every combination of register, CRm and second opcode, for both a zero and a non-zero first opcode, on coprocessors 13, 14 and 15 and on two unused numbers. This sweep separates each table entry from its neighbours. It exposes an accepted pair that should be refused, and the reverse, as well as wrong dispatch on the coprocessor number.

A second sweep repeats the legal space of the three coprocessors with the unprivileged flag set. It shows that the flag overrides every table. A third sweep clears only enable bit 13 and shows that coprocessor 13 alone loses access. Idle cycles with changing fields, and a reset in the middle of the run, check that the result is held and that reset clears it.

// File: rtl/cpgate_pkg.sv
package cpgate_pkg;

    localparam int CP_W_DEF   = 4;
    localparam int REG_W_DEF  = 4;
    localparam int CRM_W_DEF  = 4;
    localparam int OPC_W_DEF  = 3;
    localparam int EN_W_DEF   = 16;

    // Coprocessor numbers served by this checker
    localparam int CPNUM_SYS  = 15;
    localparam int CPNUM_DBG  = 14;
    localparam int CPNUM_IRQ  = 13;

    // Enable bit that gates the interrupt/bus coprocessor
    localparam int IRQ_EN_BIT = 13;

    typedef enum logic [1:0] {
        UNIT_NONE = 2'd0,
        UNIT_SYS  = 2'd1,
        UNIT_DBG  = 2'd2,
        UNIT_IRQ  = 2'd3
    } unit_sel_e;

    typedef struct packed {
        logic      user;
        unit_sel_e unit;
    } route_t;

    function automatic unit_sel_e pick_unit(input int num);
        unit_sel_e u;
        case (num)
            CPNUM_SYS: u = UNIT_SYS;
            CPNUM_DBG: u = UNIT_DBG;
            CPNUM_IRQ: u = UNIT_IRQ;
            default:   u = UNIT_NONE;
        endcase
        return u;
    endfunction

    function automatic logic in_span(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/cpgate_sys_rules.sv
module cpgate_sys_rules #(
    parameter int REG_W = 4,
    parameter int CRM_W = 4,
    parameter int OPC_W = 3
) (
    input  logic [REG_W-1:0] reg_num,
    input  logic [CRM_W-1:0] crm,
    input  logic [OPC_W-1:0] opc1,
    input  logic [OPC_W-1:0] opc2,
    output logic             ok
);
    import cpgate_pkg::*;

    int r_i;
    int m_i;
    int o2_i;
    logic table_ok;
    logic zero_pair;
    logic ctl_ok;
    logic tlb_ok;

    always_comb begin
        r_i       = int'(reg_num);
        m_i       = int'(crm);
        o2_i      = int'(opc2);
        zero_pair = (m_i == 0) && (o2_i == 0);
    end

    // Register 7: sparse (opc2, CRm) pairs
    always_comb begin
        case (o2_i)
            0:       ctl_ok = in_span(m_i, 5, 7);
            1:       ctl_ok = (m_i == 5) || (m_i == 6) || (m_i == 10);
            4:       ctl_ok = (m_i == 10);
            5:       ctl_ok = (m_i == 2);
            6:       ctl_ok = (m_i == 5);
            default: ctl_ok = 1'b0;
        endcase
    end

    // Register 8: opc2 0/1 with CRm 5..7, minus (1,7)
    always_comb begin
        tlb_ok = (o2_i <= 1) && in_span(m_i, 5, 7) && !((o2_i == 1) && (m_i == 7));
    end

    always_comb begin
        case (r_i)
            0, 1:            table_ok = (m_i == 0);
            2, 3, 5, 6, 13:  table_ok = zero_pair;
            7:               table_ok = ctl_ok;
            8:               table_ok = tlb_ok;
            9:               table_ok = ((m_i == 0) || (m_i == 1)) && ((o2_i == 1) || (o2_i == 2));
            10:              table_ok = ((m_i == 0) || (m_i == 1)) && ((o2_i == 4) || (o2_i == 8));
            14:              table_ok = (o2_i == 0) &&
                                        ((m_i == 0) || (m_i == 3) || (m_i == 4) ||
                                         (m_i == 8) || (m_i == 9));
            15:              table_ok = (o2_i == 0) && (m_i == 1);
            default:         table_ok = 1'b0;
        endcase
    end

    assign ok = (opc1 == '0) && table_ok;

endmodule

// File: rtl/cpgate_dbg_rules.sv
module cpgate_dbg_rules #(
    parameter int REG_W = 4,
    parameter int CRM_W = 4,
    parameter int OPC_W = 3
) (
    input  logic [REG_W-1:0] reg_num,
    input  logic [CRM_W-1:0] crm,
    input  logic [OPC_W-1:0] opc1,
    input  logic [OPC_W-1:0] opc2,
    output logic             ok
);
    import cpgate_pkg::*;

    logic fields_zero;
    logic reg_blocked;

    always_comb begin
        fields_zero = (crm == '0) && (opc1 == '0) && (opc2 == '0);
        reg_blocked = in_span(int'(reg_num), 4, 5);
        ok          = fields_zero && !reg_blocked;
    end

endmodule

// File: rtl/cpgate_irq_rules.sv
module cpgate_irq_rules #(
    parameter int REG_W  = 4,
    parameter int CRM_W  = 4,
    parameter int OPC_W  = 3,
    parameter int EN_W   = 16,
    parameter int EN_BIT = 13
) (
    input  logic [REG_W-1:0] reg_num,
    input  logic [CRM_W-1:0] crm,
    input  logic [OPC_W-1:0] opc1,
    input  logic [OPC_W-1:0] opc2,
    input  logic [EN_W-1:0]  cp_enable,
    output logic             ok
);
    import cpgate_pkg::*;

    int   r_i;
    logic bank0_ok;
    logic bank1_ok;
    logic gate_ok;

    always_comb begin
        r_i      = int'(reg_num);
        bank0_ok = (r_i == 0) || (r_i == 4) || (r_i == 8);
        bank1_ok = (r_i == 0) || (r_i == 1) || in_span(r_i, 4, 8);
        gate_ok  = (opc1 == '0) && (opc2 == '0) && cp_enable[EN_BIT];
        case (int'(crm))
            0:       ok = gate_ok && bank0_ok;
            1:       ok = gate_ok && bank1_ok;
            default: ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/cp_access_gate.sv
module cp_access_gate
    import cpgate_pkg::*;
#(
    parameter int CP_W   = CP_W_DEF,
    parameter int REG_W  = REG_W_DEF,
    parameter int CRM_W  = CRM_W_DEF,
    parameter int OPC_W  = OPC_W_DEF,
    parameter int EN_W   = EN_W_DEF,
    parameter int EN_BIT = IRQ_EN_BIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [CP_W-1:0]  cp_num,
    input  logic [REG_W-1:0] reg_num,
    input  logic [CRM_W-1:0] crm,
    input  logic [OPC_W-1:0] opc1,
    input  logic [OPC_W-1:0] opc2,
    input  logic             user_mode,
    input  logic [EN_W-1:0]  cp_enable,
    output logic             permit
);

    localparam int N_UNITS = 3;

    logic [N_UNITS-1:0] unit_ok;
    route_t             route;
    logic               decision;

    cpgate_sys_rules #(.REG_W(REG_W), .CRM_W(CRM_W), .OPC_W(OPC_W)) u_sys (
        .reg_num(reg_num), .crm(crm), .opc1(opc1), .opc2(opc2), .ok(unit_ok[0])
    );

    cpgate_dbg_rules #(.REG_W(REG_W), .CRM_W(CRM_W), .OPC_W(OPC_W)) u_dbg (
        .reg_num(reg_num), .crm(crm), .opc1(opc1), .opc2(opc2), .ok(unit_ok[1])
    );

    cpgate_irq_rules #(
        .REG_W(REG_W), .CRM_W(CRM_W), .OPC_W(OPC_W), .EN_W(EN_W), .EN_BIT(EN_BIT)
    ) u_irq (
        .reg_num(reg_num), .crm(crm), .opc1(opc1), .opc2(opc2),
        .cp_enable(cp_enable), .ok(unit_ok[2])
    );

    always_comb begin
        route.user = user_mode;
        route.unit = pick_unit(int'(cp_num));
        if (route.user) begin
            decision = 1'b0;
        end else begin
            case (route.unit)
                UNIT_SYS: decision = unit_ok[0];
                UNIT_DBG: decision = unit_ok[1];
                UNIT_IRQ: decision = unit_ok[2];
                default:  decision = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            permit <= 1'b0;
        end else if (req_valid) begin
            permit <= decision;
        end
    end

endmodule

// File: rtl/cpgate_checker.sv
module cpgate_checker #(
    parameter int CP_W   = 4,
    parameter int REG_W  = 4,
    parameter int CRM_W  = 4,
    parameter int OPC_W  = 3,
    parameter int EN_W   = 16,
    parameter int EN_BIT = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [CP_W-1:0]  cp_num,
    input logic [REG_W-1:0] reg_num,
    input logic [CRM_W-1:0] crm,
    input logic [OPC_W-1:0] opc1,
    input logic [OPC_W-1:0] opc2,
    input logic             user_mode,
    input logic [EN_W-1:0]  cp_enable,
    input logic             permit
);

    logic known_cp;
    assign known_cp = (int'(cp_num) >= 13) && (int'(cp_num) <= 15);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(permit)); // R1

    AST_USER_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && user_mode) |=> !permit); // R2

    AST_UNKNOWN_CP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !known_cp) |=> !permit); // R3

    AST_SYS_OPC1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(cp_num) == 15 && opc1 != '0) |=> !permit); // R4

    AST_IRQ_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(cp_num) == 13 && !cp_enable[EN_BIT]) |=> !permit); // R10

    AST_DBG_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(cp_num) == 14 && (int'(reg_num) == 4 || int'(reg_num) == 5))
        |=> !permit); // R12

    AST_SYS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(cp_num) == 15 &&
         (int'(reg_num) == 4 || int'(reg_num) == 11 || int'(reg_num) == 12))
        |=> !permit); // R5

    AST_IRQ_CRM: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(cp_num) == 13 && int'(crm) > 1) |=> !permit); // R11

endmodule

bind cp_access_gate cpgate_checker #(
    .CP_W(CP_W), .REG_W(REG_W), .CRM_W(CRM_W), .OPC_W(OPC_W), .EN_W(EN_W), .EN_BIT(EN_BIT)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .cp_num(cp_num), .reg_num(reg_num),
    .crm(crm), .opc1(opc1), .opc2(opc2), .user_mode(user_mode), .cp_enable(cp_enable),
    .permit(permit)
);

// File: tb/sim_cp_access_gate.sv
`timescale 1ns/1ps
module sim_cp_access_gate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  cp_num = '0;
    logic [3:0]  reg_num = '0;
    logic [3:0]  crm = '0;
    logic [2:0]  opc1 = '0;
    logic [2:0]  opc2 = '0;
    logic        user_mode = 1'b0;
    logic [15:0] cp_enable = '1;
    logic        permit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cp_access_gate u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .cp_num(cp_num), .reg_num(reg_num),
        .crm(crm), .opc1(opc1), .opc2(opc2), .user_mode(user_mode),
        .cp_enable(cp_enable), .permit(permit)
    );

    // Reference model computed from the requirements
    function automatic bit ref_ok(int cp, int rg, int m, int o1, int o2, bit usr, bit en13);
        int code;
        code = o2 * 16 + m;
        if (usr) return 0;                                    // R2
        if (cp == 15) begin
            if (o1 != 0) return 0;                            // R4
            if (rg <= 1) return m == 0;                       // R4
            if (rg inside {2, 3, 5, 6, 13}) return code == 0; // R5
            if (rg inside {4, 11, 12}) return 0;              // R5
            if (rg == 7) return code inside {82, 7, 26, 101, 5, 74, 22, 6, 21}; // R6
            if (rg == 8) return code inside {5, 6, 7, 21, 22};                  // R7
            if (rg == 9) return (m < 2) && (o2 == 1 || o2 == 2);                // R8
            if (rg == 10) return (m < 2) && (o2 == 4);                          // R8
            if (rg == 14) return (o2 == 0) && (m inside {9, 0, 8, 3, 4});       // R9
            return (o2 == 0) && (m == 1);                                       // R9
        end
        if (cp == 14) return (m == 0) && (o1 == 0) && (o2 == 0) && !(rg == 4 || rg == 5); // R12
        if (cp == 13) begin
            if (o1 != 0 || o2 != 0 || !en13) return 0;        // R10
            if (m == 0) return rg inside {0, 4, 8};           // R11
            if (m == 1) return rg inside {0, 1, 4, 5, 6, 7, 8}; // R11
            return 0;                                         // R11
        end
        return 0;                                             // R3
    endfunction

    function automatic string tag_of(int cp, int rg, int o1, bit usr, bit en13);
        if (usr) return "R2";
        if (cp == 14) return "R12";
        if (cp == 13) return en13 && o1 == 0 ? "R11" : "R10";
        if (cp != 15) return "R3";
        if (o1 != 0 || rg <= 1) return "R4";
        case (rg)
            7: return "R6";
            8: return "R7";
            9, 10: return "R8";
            14, 15: return "R9";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: permit=%0d expected=%0d (cp=%0d reg=%0d crm=%0d opc1=%0d opc2=%0d user=%0d)",
                     tag, got, exp, cp_num, reg_num, crm, opc1, opc2, user_mode);
        end
    endtask

    task automatic issue(input int cp, input int rg, input int m, input int o1, input int o2,
                         input bit usr, input bit en13);
        @(negedge clk);
        cp_num    = 4'(cp);
        reg_num   = 4'(rg);
        crm       = 4'(m);
        opc1      = 3'(o1);
        opc2      = 3'(o2);
        user_mode = usr;
        cp_enable = en13 ? 16'hFFFF : 16'hDFFF;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(permit, ref_ok(cp, rg, m, o1, o2, usr, en13), tag_of(cp, rg, o1, usr, en13));
    endtask

    initial begin
        int cps[5];
        cps = '{0, 12, 13, 14, 15};
        repeat (3) @(negedge clk);
        check(permit, 1'b0, "R1");           // reset value
        rst = 1'b0;

        // Sweep 1: privileged, all enables, every field combination
        foreach (cps[k])
            for (int o1 = 0; o1 < 2; o1++)
                for (int o2 = 0; o2 < 8; o2++)
                    for (int m = 0; m < 16; m++)
                        for (int rg = 0; rg < 16; rg++)
                            issue(cps[k], rg, m, o1, o2, 1'b0, 1'b1);

        // Sweep 2: unprivileged overrides every table (R2)
        for (int cp = 13; cp < 16; cp++)
            for (int o2 = 0; o2 < 8; o2++)
                for (int m = 0; m < 16; m++)
                    for (int rg = 0; rg < 16; rg++)
                        issue(cp, rg, m, 0, o2, 1'b1, 1'b1);

        // Sweep 3: enable bit 13 cleared; coprocessor 13 refused (R10), 14/15 unaffected
        for (int cp = 13; cp < 16; cp++)
            for (int m = 0; m < 4; m++)
                for (int rg = 0; rg < 16; rg++)
                    issue(cp, rg, m, 0, 0, 1'b0, 1'b0);

        // Hold behaviour (R1): accepted result stays while strobe is low
        issue(15, 0, 0, 0, 3, 1'b0, 1'b1);
        check(permit, 1'b1, "R1");
        user_mode = 1'b1;
        cp_num = 4'd2;
        repeat (4) @(negedge clk);
        check(permit, 1'b1, "R1");
        issue(14, 4, 0, 0, 0, 1'b0, 1'b1);
        cp_num = 4'd15;
        reg_num = 4'd0;
        repeat (4) @(negedge clk);
        check(permit, 1'b0, "R1");

        // Reset in mid-run clears an accept (R1)
        issue(13, 8, 0, 0, 0, 1'b0, 1'b1);
        check(permit, 1'b1, "R1");
        rst = 1'b1;
        @(negedge clk);
        check(permit, 1'b0, "R1");
        rst = 1'b0;

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: done=0 expected=1");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule